// File: doc/BRIEF.md
# Clock Stop and Wake Sequencer

This block steps a chip's clock tree down into a clock-stopped low-power state and brings it back. It owns four enable outputs: system clock, PLL, reference clock and oscillator buffer. Software turns them off one at a time, in a fixed order, through register writes. The block refuses any write that breaks the order or arrives too soon after the previous step, and records the refusal in a sticky error bit.

Once the oscillator enable is off the chip is stopped. A bus resume pulse or a VBUS-change pulse then pulls the active-low interrupt low and records which event caused it. With auto mode on, a resume turns the oscillator back on in hardware. A VBUS change always waits for software to do that. Each time the oscillator comes back on, a recovery window of fixed length starts. During it, hardware turns the other three enables back on in the reverse of the shutdown order, one every STEP_CYC cycles. Register access is also blocked during the window: writes are dropped, reads return zero, and any chip-select sets a sticky access-error bit. Every duration is a cycle-count parameter, so a bench can shorten them.

Write selector codes on `wr_sel_i`: 0 system clock, 1 PLL, 2 reference clock, 3 oscillator, 4 clear resume cause, 5 clear VBUS cause, 6 clear both error bits. Status bits on `rd_data_o`: [0] oscillator, [1] reference, [2] PLL, [3] system, [4] resume cause, [5] VBUS cause, [6] sequence error, [7] access error.

Top module: `clk_pwr_seq`

## Requirements
- R1: After reset all four enables are 1, `irq_no` is 1, `acc_ready_o` is 1, and a read returns 8'h0F.
- R2: A clear (`wr_val_i`=0) of stage k (selector 1, 2 or 3) is accepted only when stage k-1 is already 0. Otherwise it is ignored and status bit 6 is set. Clearing the system clock (selector 0) is always accepted.
- R3: A clear of a later stage is accepted only when it is sampled at least GAP_CYC cycles after the edge that took the previous accepted clear. A clear sampled sooner is ignored and sets status bit 6.
- R4: When the oscillator enable is 0 and auto mode is 1, a resume pulse sets the oscillator enable one cycle later. In that same cycle `irq_no` goes low and status bit 4 is set.
- R5: When auto mode is 0, a resume pulse in the stopped state pulls `irq_no` low and sets bit 4, but the oscillator stays off until software writes selector 3 with value 1.
- R6: A VBUS-change pulse in the stopped state pulls `irq_no` low and sets bit 5, whatever the mode. The oscillator stays off until software writes selector 3 with value 1.
- R7: `acc_ready_o` is 0 for exactly WIN_CYC cycles, starting in the cycle in which the oscillator enable first reads 1.
- R8: Counted from the cycle in which the oscillator enable first reads 1, the reference enable rises STEP_CYC cycles later, the PLL enable 2*STEP_CYC cycles later and the system enable 3*STEP_CYC cycles later.
- R9: While `acc_ready_o` is 0, writes are ignored and `rd_data_o` is 0. A chip-select in that time sets status bit 7.
- R10: Selector 4 clears bit 4 and selector 5 clears bit 5. `irq_no` stays low while either cause bit is set. Selector 6 clears bits 6 and 7.
- R11: Resume and VBUS-change pulses that arrive while the oscillator enable is 1 have no effect on the interrupt or the cause bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_i | input | 1 | Chip select; a read is returned while high |
| wr_i | input | 1 | Write strobe, qualified by cs_i |
| wr_sel_i | input | 3 | Write target selector |
| wr_val_i | input | 1 | Value written to a stage enable |
| auto_mode_i | input | 1 | Hardware wake on resume |
| resume_i | input | 1 | Bus resume event pulse |
| vbus_chg_i | input | 1 | VBUS change event pulse |
| osc_en_o | output | 1 | Oscillator buffer enable |
| ref_en_o | output | 1 | Reference clock enable |
| pll_en_o | output | 1 | PLL enable |
| sys_en_o | output | 1 | System clock enable |
| irq_no | output | 1 | Wake interrupt, active low |
| acc_ready_o | output | 1 | Register access allowed |
| rd_data_o | output | 8 | Status read data |

## Verification
A write or event driven on a falling edge is taken at the next rising edge. Its effect on the enables, the interrupt and `acc_ready_o` is due in that same cycle. The scoreboard therefore tags each expected item with the cycle number one past the drive cycle. Read data is combinational from `cs_i` and is compared in that same cycle. For a wake, the driver pushes, in one step, items due STEP_CYC, 2*STEP_CYC, 3*STEP_CYC and WIN_CYC cycles after the oscillator rises. It also pushes items one cycle earlier, which must still show the old value, so that the boundaries of R3, R7 and R8 are pinned to the exact cycle.

// File: rtl/clk_pwr_pkg.sv
package clk_pwr_pkg;
  localparam int unsigned NUM_STAGES = 4;

  // stage index equals shutdown position
  localparam int unsigned STG_SYS = 0;
  localparam int unsigned STG_PLL = 1;
  localparam int unsigned STG_REF = 2;
  localparam int unsigned STG_OSC = 3;

  typedef enum logic [2:0] {
    SEL_SYS      = 3'd0,
    SEL_PLL      = 3'd1,
    SEL_REF      = 3'd2,
    SEL_OSC      = 3'd3,
    SEL_CLR_RES  = 3'd4,
    SEL_CLR_VBUS = 3'd5,
    SEL_CLR_ERR  = 3'd6,
    SEL_NONE     = 3'd7
  } wsel_e;

  typedef struct packed {
    logic acc_err;
    logic seq_err;
    logic cause_vbus;
    logic cause_res;
    logic sys;
    logic pll;
    logic refc;
    logic osc;
  } status_t;
endpackage

// File: rtl/pwr_span_cnt.sv
module pwr_span_cnt #(
  parameter int unsigned MAX = 16,
  parameter int unsigned W   = $clog2(MAX + 1)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         restart_i,
  input  logic         en_i,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          cnt_q <= '0;
    else if (restart_i)                   cnt_q <= W'(1);
    else if (en_i && cnt_q != W'(MAX))    cnt_q <= cnt_q + W'(1);
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/pwr_wake_cause.sv
module pwr_wake_cause (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stopped_i,
  input  logic resume_i,
  input  logic vbus_chg_i,
  input  logic clr_res_i,
  input  logic clr_vbus_i,
  output logic cause_res_o,
  output logic cause_vbus_o,
  output logic irq_no
);
  logic res_q, vbus_q;

  // a new event wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q  <= 1'b0;
      vbus_q <= 1'b0;
    end else begin
      if (stopped_i && resume_i)   res_q <= 1'b1;
      else if (clr_res_i)          res_q <= 1'b0;
      if (stopped_i && vbus_chg_i) vbus_q <= 1'b1;
      else if (clr_vbus_i)         vbus_q <= 1'b0;
    end
  end

  assign cause_res_o  = res_q;
  assign cause_vbus_o = vbus_q;
  assign irq_no       = ~(res_q | vbus_q);
endmodule

// File: rtl/clk_pwr_seq.sv
module clk_pwr_seq
  import clk_pwr_pkg::*;
#(
  parameter int unsigned GAP_CYC  = 38,
  parameter int unsigned STEP_CYC = 1000,
  parameter int unsigned WIN_CYC  = 312500
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cs_i,
  input  logic       wr_i,
  input  logic [2:0] wr_sel_i,
  input  logic       wr_val_i,
  input  logic       auto_mode_i,
  input  logic       resume_i,
  input  logic       vbus_chg_i,
  output logic       osc_en_o,
  output logic       ref_en_o,
  output logic       pll_en_o,
  output logic       sys_en_o,
  output logic       irq_no,
  output logic       acc_ready_o,
  output logic [7:0] rd_data_o
);
  localparam int unsigned GAP_W = $clog2(GAP_CYC + 1);
  localparam int unsigned WIN_W = $clog2(WIN_CYC + 1);

  logic [NUM_STAGES-1:0] en_q, en_d;
  logic [NUM_STAGES-1:0] clr_legal;
  logic [NUM_STAGES-2:0] restore;
  logic                  busy_q, seq_err_q, acc_err_q;
  logic [GAP_W-1:0]      gap_cnt;
  logic [WIN_W-1:0]      win_cnt;
  wsel_e                 wsel;
  logic [1:0]            stage_idx;
  logic                  wr_ok, gap_ok, stopped;
  logic                  clr_req, clr_acc, clr_bad;
  logic                  sw_wake, hw_wake, wake, win_done;
  logic                  cause_res, cause_vbus;
  status_t               stat;

  assign wsel      = wsel_e'(wr_sel_i);
  assign stage_idx = wr_sel_i[1:0];
  assign wr_ok     = cs_i & wr_i & ~busy_q;
  assign gap_ok    = gap_cnt >= GAP_W'(GAP_CYC);
  assign stopped   = ~en_q[STG_OSC];

  // shutdown legality per stage: predecessor off and dwell met
  for (genvar g = 0; g < NUM_STAGES; g++) begin : g_legal
    if (g == 0) begin : g_first
      assign clr_legal[g] = 1'b1;
    end else begin : g_next
      assign clr_legal[g] = ~en_q[g-1] & gap_ok;
    end
  end

  assign clr_req = wr_ok & ~wr_sel_i[2] & ~wr_val_i & en_q[stage_idx];
  assign clr_acc = clr_req & clr_legal[stage_idx];
  assign clr_bad = clr_req & ~clr_legal[stage_idx];

  assign sw_wake = wr_ok & (wsel == SEL_OSC) & wr_val_i & stopped;
  assign hw_wake = stopped & resume_i & auto_mode_i;
  assign wake    = sw_wake | hw_wake;

  // wake restores in reverse order: ref at 1 step, pll at 2, sys at 3
  for (genvar g = 0; g < NUM_STAGES - 1; g++) begin : g_restore
    localparam int unsigned POINT = (NUM_STAGES - 1 - g) * STEP_CYC;
    assign restore[g] = busy_q & (win_cnt == WIN_W'(POINT));
  end

  assign win_done = busy_q & (win_cnt == WIN_W'(WIN_CYC));

  always_comb begin
    en_d = en_q;
    if (clr_acc) en_d[stage_idx] = 1'b0;
    if (wake)    en_d[STG_OSC]   = 1'b1;
    for (int g = 0; g < NUM_STAGES - 1; g++) begin
      if (restore[g]) en_d[g] = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q      <= '1;
      busy_q    <= 1'b0;
      seq_err_q <= 1'b0;
      acc_err_q <= 1'b0;
    end else begin
      en_q   <= en_d;
      busy_q <= wake | (busy_q & ~win_done);
      if (clr_bad)                            seq_err_q <= 1'b1;
      else if (wr_ok && wsel == SEL_CLR_ERR)  seq_err_q <= 1'b0;
      if (cs_i && busy_q)                     acc_err_q <= 1'b1;
      else if (wr_ok && wsel == SEL_CLR_ERR)  acc_err_q <= 1'b0;
    end
  end

  pwr_span_cnt #(.MAX(GAP_CYC), .W(GAP_W)) u_gap_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (clr_acc),
    .en_i      (1'b1),
    .cnt_o     (gap_cnt)
  );

  pwr_span_cnt #(.MAX(WIN_CYC), .W(WIN_W)) u_win_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (wake),
    .en_i      (busy_q),
    .cnt_o     (win_cnt)
  );

  pwr_wake_cause u_cause (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .stopped_i    (stopped),
    .resume_i     (resume_i),
    .vbus_chg_i   (vbus_chg_i),
    .clr_res_i    (wr_ok && wsel == SEL_CLR_RES),
    .clr_vbus_i   (wr_ok && wsel == SEL_CLR_VBUS),
    .cause_res_o  (cause_res),
    .cause_vbus_o (cause_vbus),
    .irq_no       (irq_no)
  );

  always_comb begin
    stat.acc_err    = acc_err_q;
    stat.seq_err    = seq_err_q;
    stat.cause_vbus = cause_vbus;
    stat.cause_res  = cause_res;
    stat.sys        = en_q[STG_SYS];
    stat.pll        = en_q[STG_PLL];
    stat.refc       = en_q[STG_REF];
    stat.osc        = en_q[STG_OSC];
  end

  assign rd_data_o   = (cs_i && !busy_q) ? stat : 8'h00;
  assign acc_ready_o = ~busy_q;
  assign osc_en_o    = en_q[STG_OSC];
  assign ref_en_o    = en_q[STG_REF];
  assign pll_en_o    = en_q[STG_PLL];
  assign sys_en_o    = en_q[STG_SYS];
endmodule

// File: rtl/clk_pwr_seq_chk.sv
module clk_pwr_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cs_i,
  input logic       wr_i,
  input logic [2:0] wr_sel_i,
  input logic       wr_val_i,
  input logic       auto_mode_i,
  input logic       resume_i,
  input logic       vbus_chg_i,
  input logic       osc_en_o,
  input logic       ref_en_o,
  input logic       pll_en_o,
  input logic       sys_en_o,
  input logic       irq_no,
  input logic       acc_ready_o,
  input logic [7:0] rd_data_o
);
  logic sw_osc_set;
  assign sw_osc_set = cs_i && wr_i && wr_sel_i == 3'd3 && wr_val_i;

  assert_sys_before_pll_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pll_en_o) |-> $past(!sys_en_o));
  assert_pll_before_ref_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ref_en_o) |-> $past(!pll_en_o));
  assert_ref_before_osc_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(osc_en_o) |-> $past(!ref_en_o));
  assert_auto_resume_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resume_i && auto_mode_i && !osc_en_o) |=> (osc_en_o && !irq_no));
  assert_vbus_no_wake_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vbus_chg_i && !osc_en_o && !(resume_i && auto_mode_i) && !sw_osc_set)
      |=> (!osc_en_o && !irq_no));
  assert_window_opens_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(osc_en_o) |-> !acc_ready_o);
  assert_sys_last_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sys_en_o) |-> (pll_en_o && ref_en_o && osc_en_o));
  assert_pll_after_ref_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pll_en_o) |-> ref_en_o);
  assert_blocked_read_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_ready_o |-> rd_data_o == 8'h00);
  assert_awake_ignores_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (osc_en_o && irq_no) |=> irq_no);
endmodule

bind clk_pwr_seq clk_pwr_seq_chk u_chk (.*);

// File: tb/clk_pwr_seq_test.sv
module clk_pwr_seq_test;
  localparam int GAP  = 4;
  localparam int STEP = 8;
  localparam int WIN  = 40;

  localparam logic [13:0] M_OSC = 14'h2000, M_REF = 14'h1000, M_PLL = 14'h0800,
                          M_SYS = 14'h0400, M_IRQ = 14'h0200, M_RDY = 14'h0100,
                          M_RD  = 14'h00FF, M_EN  = 14'h3C00;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       cs = 1'b0, wr = 1'b0, wr_val = 1'b0, auto_mode = 1'b0;
  logic       resume = 1'b0, vbus = 1'b0;
  logic [2:0] wr_sel = 3'd7;
  logic       osc_en, ref_en, pll_en, sys_en, irq_n, acc_ready;
  logic [7:0] rd_data;

  int cyc = 0, n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  typedef struct {
    int          due;
    logic [13:0] mask;
    logic [13:0] val;
    string       req;
  } item_t;
  item_t sb[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  clk_pwr_seq #(.GAP_CYC(GAP), .STEP_CYC(STEP), .WIN_CYC(WIN)) uut (
    .clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .wr_i(wr), .wr_sel_i(wr_sel),
    .wr_val_i(wr_val), .auto_mode_i(auto_mode), .resume_i(resume),
    .vbus_chg_i(vbus), .osc_en_o(osc_en), .ref_en_o(ref_en), .pll_en_o(pll_en),
    .sys_en_o(sys_en), .irq_no(irq_n), .acc_ready_o(acc_ready), .rd_data_o(rd_data)
  );

  // monitor: compare due items shortly after each rising edge
  initial forever begin
    @(posedge clk);
    #2;
    for (int i = sb.size() - 1; i >= 0; i--) begin
      if (sb[i].due == cyc) begin
        logic [13:0] obs;
        obs = {osc_en, ref_en, pll_en, sys_en, irq_n, acc_ready, rd_data};
        n_chk++;
        if ((obs & sb[i].mask) != (sb[i].val & sb[i].mask)) begin
          n_fail++;
          $display("FAIL %s cyc=%0d actual=%h expected=%h mask=%h",
                   sb[i].req, cyc, obs & sb[i].mask, sb[i].val & sb[i].mask, sb[i].mask);
        end
        sb.delete(i);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(8 * 20000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired at cyc=%0d", cyc);
    finish_run();
  end

  task automatic exp(int d, logic [13:0] mask, logic [13:0] val, string req);
    item_t it;
    it.due = cyc + d; it.mask = mask; it.val = val; it.req = req;
    sb.push_back(it);
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_until(int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic wr_reg(logic [2:0] sel, logic val);
    cs = 1'b1; wr = 1'b1; wr_sel = sel; wr_val = val;
    @(negedge clk);
    cs = 1'b0; wr = 1'b0; wr_sel = 3'd7; wr_val = 1'b0;
  endtask

  task automatic rd_reg();
    cs = 1'b1;
    @(negedge clk);
    cs = 1'b0;
  endtask

  task automatic shutdown();
    int t;
    t = 0;
    for (int s = 0; s < 4; s++) begin
      if (s > 0) wait_until(t + GAP);
      t = cyc;
      wr_reg(3'(s), 1'b0);
    end
    exp(1, M_EN, 14'h0000, "R2 full shutdown");
    tick(1);
  endtask

  initial begin
    int t, c1;
    tick(2);
    rst_n = 1'b1;
    tick(1);

    // R1 reset state
    exp(1, 14'h3FFF, {4'hF, 1'b1, 1'b1, 8'h0F}, "R1 reset state");
    rd_reg();

    // R2 out-of-order clear of the PLL
    exp(1, M_PLL | M_SYS, M_PLL | M_SYS, "R2 pll clear ignored");
    wr_reg(3'd1, 1'b0);
    exp(1, M_RD, 14'h004F, "R2 seq error set");
    rd_reg();
    wr_reg(3'd6, 1'b0);
    exp(1, M_RD, 14'h000F, "R10 error clear");
    rd_reg();

    // R3 dwell boundary
    t = cyc;
    wr_reg(3'd0, 1'b0);
    exp(1, M_SYS | M_PLL, M_PLL, "R3 early clear ignored");
    wr_reg(3'd1, 1'b0);
    wait_until(t + GAP - 1);
    exp(1, M_PLL, M_PLL, "R3 one cycle short");
    wr_reg(3'd1, 1'b0);
    exp(1, M_PLL, 14'h0000, "R3 clear at gap");
    wr_reg(3'd1, 1'b0);
    exp(1, M_RD, 14'h0043, "R3 seq error");
    rd_reg();
    wr_reg(3'd6, 1'b0);
    t = t + GAP;
    wait_until(t + GAP);
    t = cyc;
    wr_reg(3'd2, 1'b0);
    wait_until(t + GAP);
    wr_reg(3'd3, 1'b0);
    exp(1, M_RD | M_IRQ | M_RDY, 14'h0300, "R2 stopped clean");
    rd_reg();

    // R5 resume without auto mode
    auto_mode = 1'b0;
    resume = 1'b1;
    exp(1, M_OSC | M_IRQ | M_RDY, M_RDY, "R5 irq without wake");
    tick(1);
    resume = 1'b0;
    tick(3);
    exp(1, M_OSC | M_RD, 14'h0010, "R5 osc stays off");
    rd_reg();

    // software wake: R7 window, R8 restore order
    c1 = cyc;
    exp(1, M_OSC | M_REF | M_RDY, M_OSC, "R7 window opens");
    exp(STEP, M_REF, 14'h0000, "R8 ref not yet");
    exp(STEP + 1, M_REF | M_PLL, M_REF, "R8 ref on");
    exp(2 * STEP, M_PLL, 14'h0000, "R8 pll not yet");
    exp(2 * STEP + 1, M_PLL | M_SYS, M_PLL, "R8 pll on");
    exp(3 * STEP, M_SYS, 14'h0000, "R8 sys not yet");
    exp(3 * STEP + 1, M_SYS, M_SYS, "R8 sys on");
    exp(WIN, M_RDY, 14'h0000, "R7 last blocked cycle");
    exp(WIN + 1, M_RDY, M_RDY, "R7 window closes");
    wr_reg(3'd3, 1'b1);
    wait_until(c1 + 3);
    exp(1, M_RD | M_IRQ, 14'h0000, "R9 blocked write and read");
    wr_reg(3'd4, 1'b0);
    wait_until(c1 + WIN + 2);
    exp(1, M_RD, 14'h009F, "R9 access error recorded");
    rd_reg();
    exp(1, M_IRQ, M_IRQ, "R10 resume cause cleared");
    wr_reg(3'd4, 1'b0);
    wr_reg(3'd6, 1'b0);
    exp(1, M_RD, 14'h000F, "R10 errors cleared");
    rd_reg();

    // R4 auto resume
    shutdown();
    auto_mode = 1'b1;
    c1 = cyc;
    resume = 1'b1;
    exp(1, M_OSC | M_IRQ | M_RDY, M_OSC, "R4 hardware wake");
    exp(STEP + 1, M_REF, M_REF, "R8 ref on auto");
    exp(WIN + 1, M_RDY | M_EN, M_RDY | M_EN, "R7 window end auto");
    tick(1);
    resume = 1'b0;
    wait_until(c1 + WIN + 2);
    exp(1, M_RD, 14'h001F, "R4 resume cause");
    rd_reg();
    wr_reg(3'd4, 1'b0);

    // R6 VBUS change
    shutdown();
    vbus = 1'b1;
    exp(1, M_OSC | M_IRQ, 14'h0000, "R6 no auto wake");
    tick(1);
    vbus = 1'b0;
    tick(4);
    exp(1, M_OSC | M_RD, 14'h0020, "R6 vbus cause");
    rd_reg();
    exp(1, M_IRQ, 14'h0000, "R10 other cause holds irq");
    wr_reg(3'd4, 1'b0);
    c1 = cyc;
    exp(1, M_OSC | M_RDY, M_OSC, "R6 software wake");
    wr_reg(3'd3, 1'b1);
    wait_until(c1 + WIN + 2);
    exp(1, M_RD | M_IRQ, 14'h002F, "R6 restored");
    rd_reg();
    exp(1, M_IRQ, M_IRQ, "R10 vbus cause cleared");
    wr_reg(3'd5, 1'b0);

    // R11 events while running
    resume = 1'b1; vbus = 1'b1;
    exp(1, M_IRQ | M_OSC, M_IRQ | M_OSC, "R11 events ignored");
    tick(1);
    resume = 1'b0; vbus = 1'b0;
    exp(1, M_RD, 14'h000F, "R11 no cause bits");
    rd_reg();

    tick(3);
    if (sb.size() != 0) begin
      n_fail += sb.size();
      $display("FAIL scoreboard: %0d items never compared", sb.size());
    end
    finish_run();
  end
endmodule